// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block sits between instruction decode and a multi-issue micro-op queue. It takes one scalar-encoded instruction with three architectural operands (destination and two sources, 5 bits each) and a per-element predicate mask. Each operand is looked up in a small tag table. A tag can send the operand to any of 128 physical registers, give it its own element width, and mark it as a vector. If any operand resolves to a vector tag, the instruction is unrolled into one micro-op per element. Vector operands step through consecutive physical registers. Scalar operands keep the same register on every element.

Elements whose predicate bit is clear are never sent. A priority encoder jumps straight over them, so masked runs take no cycles and free queue bandwidth for later work. Up to two micro-ops go out together on a single valid/ready transfer. When the last element has been sent, a one-cycle done pulse follows, and the block is then ready for the next instruction. Software loads the tag table and the vector length through a simple write port.

Top module: `vis_seq`

## Requirements
- R1: After reset `ins_ready` is 1, `out0_valid`, `out1_valid` and `done` are 0, all tag slots are invalid and the vector length is 0.
- R2: A `cfg_we` pulse writes slot `cfg_slot`. An operand matches a slot that is valid and has an equal architectural index, and the lowest-numbered matching slot wins. A matched operand takes the slot's physical base and width code. An unmatched operand keeps its own number, zero-extended to 7 bits, with width code 0.
- R3: If any operand matches a slot whose vector flag is 1, element i runs over i = 0 up to min(VL, MAX_VL) - 1. For element i, each vector-tagged operand uses physical register base + i modulo 128, and every other operand stays fixed.
- R4: A vector element is issued only if `ins_pred[i]` is 1, in ascending element order. Slot 0 carries the lowest element not yet sent and slot 1 the next one. Masked elements cost no transfer, so n issued elements need ceil(n/2) accepted transfers.
- R5: If no operand matches a vector-flagged slot, exactly one micro-op with element index 0 is issued and the predicate is ignored.
- R6: The width codes (0=64, 1=32, 2=16, 3=8 bits) travel per operand. Two architectural registers may map to the same physical register with different widths.
- R7: While a slot is valid and `out_ready` is 0, both slots hold their contents. The block advances only on a transfer (`out0_valid` and `out_ready` both 1).
- R8: `done` is high for exactly one cycle, in the cycle after the last transfer, or in the cycle after acceptance if nothing is to be issued. `ins_ready` is 0 from acceptance until the cycle after `done`, when it is 1 again.
- R9: Micro-op layout, MSB to LSB, with the defaults: op[40:33], element index[32:27], rd width[26:25], rd[24:18], rs1 width[17:16], rs1[15:9], rs2 width[8:7], rs2[6:0].
- R10: Tag and length writes made after an instruction is accepted do not change the micro-ops of that instruction.
- R11: With a vector-tagged operand and VL = 0, or no predicate bit set within VL, nothing is issued and `done` still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Tag slot write strobe |
| cfg_slot | input | 2 | Tag slot to write |
| cfg_valid | input | 1 | Written slot is valid |
| cfg_areg | input | 5 | Architectural register matched by the slot |
| cfg_preg | input | 7 | Physical base register |
| cfg_ew | input | 2 | Element width code |
| cfg_vec | input | 1 | Slot marks a vector |
| vl_we | input | 1 | Vector length write strobe |
| vl_val | input | 7 | New vector length |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Sequencer idle, instruction taken |
| ins_op | input | 8 | Opcode carried to each micro-op |
| ins_rd | input | 5 | Destination register |
| ins_rs1 | input | 5 | First source register |
| ins_rs2 | input | 5 | Second source register |
| ins_pred | input | 64 | Element predicate mask |
| out_ready | input | 1 | Queue accepts both slots |
| out0_valid | output | 1 | Slot 0 holds a micro-op |
| out0_uop | output | 41 | Slot 0 micro-op |
| out1_valid | output | 1 | Slot 1 holds a micro-op |
| out1_uop | output | 41 | Slot 1 micro-op |
| done | output | 1 | Instruction fully issued |

## Verification
The assertions check the issue protocol on every cycle. Slot 1 is never valid without slot 0, and slot 1's element index is always above slot 0's. Stalled slots hold still, done is a single-cycle pulse followed by readiness, nothing is issued while idle, and acceptance drops `ins_ready`. Only the bench's scenarios can show that the register numbers, widths and element indices are correct. The same is true for tag priority, wraparound, skipping of masked elements at two per transfer, the scalar fallback, zero-length vectors and isolation from late configuration writes. The bench checks these by comparing against a model that is independent of the RTL, under random masks, random tags and random backpressure.

// File: rtl/vis_pkg.sv
// Shared widths and types for the vector element issue sequencer.
// Assumes three operands per instruction: index 0 = rd, 1 = rs1, 2 = rs2.
package vis_pkg;
    localparam int AREG_W = 5;
    localparam int PREG_W = 7;
    localparam int EW_W   = 2;
    localparam int NOPS   = 3;

    typedef struct packed {
        logic              valid;
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] preg;
        logic [EW_W-1:0]   ew;
        logic              vec;
    } tag_t;

    typedef struct packed {
        logic              hit;
        logic [PREG_W-1:0] preg;
        logic [EW_W-1:0]   ew;
        logic              vec;
    } opmap_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_t;
endpackage

// File: rtl/vis_tag_table.sv
// Register tag table: NUM_TAGS slots written one at a time, with a
// fully associative lookup for each operand. Assumes the lowest-numbered
// matching valid slot takes priority.
module vis_tag_table
    import vis_pkg::*;
#(
    parameter int NUM_TAGS = 4,
    localparam int SLOT_W  = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  tag_t                         wr_data,
    input  logic [NOPS-1:0][AREG_W-1:0]  q_areg,
    output opmap_t [NOPS-1:0]            q_map
);
    tag_t tbl [NUM_TAGS];

    // Slot storage: clear on reset, overwrite on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TAGS; t++) tbl[t] <= '0;
        end else if (wr) begin
            tbl[wr_slot] <= wr_data;
        end
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_look
        opmap_t res;
        // Associative search; scanning downwards lets the lowest slot win.
        always_comb begin
            res = '0;
            for (int t = NUM_TAGS - 1; t >= 0; t--) begin
                if (tbl[t].valid && tbl[t].areg == q_areg[g])
                    res = '{hit: 1'b1, preg: tbl[t].preg, ew: tbl[t].ew, vec: tbl[t].vec};
            end
        end
        assign q_map[g] = res;
    end
endmodule

// File: rtl/vis_pick2.sv
// Finds the two lowest set bits of a mask in one cycle.
// Assumes N >= 2; the second result is only meaningful when second_ok is set.
module vis_pick2 #(
    parameter int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] first,
    output logic          first_ok,
    output logic [IW-1:0] second,
    output logic          second_ok
);
    logic [N-1:0] rest;

    // Lowest set bit of the full mask.
    always_comb begin
        first    = '0;
        first_ok = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first    = IW'(i);
                first_ok = 1'b1;
            end
        end
    end

    // Lowest set bit once the first one is removed.
    always_comb begin
        rest = mask;
        if (first_ok) rest[first] = 1'b0;
        second    = '0;
        second_ok = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rest[i]) begin
                second    = IW'(i);
                second_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vis_seq.sv
// Vector element issue sequencer top. It accepts one instruction while
// idle, resolves its operands through the tag table, then issues up to two
// predicated element micro-ops per accepted transfer. Masked elements are
// skipped for free. Assumes the queue takes both slots together on out_ready.
module vis_seq
    import vis_pkg::*;
#(
    parameter int NUM_TAGS = 4,
    parameter int MAX_VL   = 64,
    parameter int OP_W     = 8,
    localparam int SLOT_W  = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    localparam int VL_W    = $clog2(MAX_VL + 1),
    localparam int IW      = $clog2(MAX_VL),
    localparam int FLD_W   = EW_W + PREG_W,
    localparam int UOP_W   = OP_W + IW + NOPS * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_valid,
    input  logic [AREG_W-1:0] cfg_areg,
    input  logic [PREG_W-1:0] cfg_preg,
    input  logic [EW_W-1:0]   cfg_ew,
    input  logic              cfg_vec,
    input  logic              vl_we,
    input  logic [VL_W-1:0]   vl_val,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [AREG_W-1:0] ins_rd,
    input  logic [AREG_W-1:0] ins_rs1,
    input  logic [AREG_W-1:0] ins_rs2,
    input  logic [MAX_VL-1:0] ins_pred,
    input  logic              out_ready,
    output logic              out0_valid,
    output logic [UOP_W-1:0]  out0_uop,
    output logic              out1_valid,
    output logic [UOP_W-1:0]  out1_uop,
    output logic              done
);
    seq_state_t                     state;
    logic [VL_W-1:0]                vl_q;
    logic [OP_W-1:0]                ctx_op;
    logic [NOPS-1:0][PREG_W-1:0]    ctx_base;
    logic [NOPS-1:0][EW_W-1:0]      ctx_ew;
    logic [NOPS-1:0]                ctx_vec;
    logic [MAX_VL-1:0]              rem;

    opmap_t [NOPS-1:0]              map;
    logic [NOPS-1:0][AREG_W-1:0]    qry;
    logic [NOPS-1:0]                vec_hit;
    logic                           any_vec;
    logic [MAX_VL-1:0]              len_mask;
    logic [MAX_VL-1:0]              start_mask;
    logic [IW-1:0]                  e0, e1;
    logic                           e0_ok, e1_ok;
    logic [MAX_VL-1:0]              clr, rem_next;
    logic                           accept, xfer;

    assign qry = {ins_rs2, ins_rs1, ins_rd};

    vis_tag_table #(.NUM_TAGS(NUM_TAGS)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_we),
        .wr_slot (cfg_slot),
        .wr_data ('{valid: cfg_valid, areg: cfg_areg, preg: cfg_preg, ew: cfg_ew, vec: cfg_vec}),
        .q_areg  (qry),
        .q_map   (map)
    );

    vis_pick2 #(.N(MAX_VL)) u_pick (
        .mask      (rem),
        .first     (e0),
        .first_ok  (e0_ok),
        .second    (e1),
        .second_ok (e1_ok)
    );

    // Which operands are vector-tagged, and the element range set by VL.
    always_comb begin
        for (int g = 0; g < NOPS; g++) vec_hit[g] = map[g].hit & map[g].vec;
        any_vec = |vec_hit;
        for (int i = 0; i < MAX_VL; i++) len_mask[i] = (VL_W'(i) < vl_q);
        start_mask = any_vec ? (ins_pred & len_mask) : MAX_VL'(1);
    end

    assign ins_ready = (state == ST_IDLE);
    assign accept    = ins_valid & ins_ready;
    assign xfer      = (state == ST_RUN) & out_ready;

    // Bits retired by one transfer, and what remains after it.
    always_comb begin
        clr = '0;
        if (e0_ok) clr[e0] = 1'b1;
        if (e1_ok) clr[e1] = 1'b1;
        rem_next = rem & ~clr;
    end

    // Vector length register, written through the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n)     vl_q <= '0;
        else if (vl_we) vl_q <= vl_val;
    end

    // Instruction context capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_op   <= '0;
            ctx_base <= '0;
            ctx_ew   <= '0;
            ctx_vec  <= '0;
        end else if (accept) begin
            ctx_op <= ins_op;
            for (int g = 0; g < NOPS; g++) begin
                ctx_base[g] <= map[g].hit ? map[g].preg : PREG_W'(qry[g]);
                ctx_ew[g]   <= map[g].hit ? map[g].ew : '0;
                ctx_vec[g]  <= vec_hit[g];
            end
        end
    end

    // Sequencing: idle -> run while elements remain -> one-cycle finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    rem   <= start_mask;
                    state <= (start_mask == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (xfer) begin
                    rem <= rem_next;
                    if (rem_next == '0) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Micro-op word for one element index: op, index, then rd/rs1/rs2 fields.
    function automatic logic [UOP_W-1:0] build_uop(logic [IW-1:0] idx);
        logic [NOPS*FLD_W-1:0] f;
        for (int g = 0; g < NOPS; g++)
            f[(NOPS-1-g)*FLD_W +: FLD_W] =
                {ctx_ew[g], ctx_base[g] + (ctx_vec[g] ? PREG_W'(idx) : PREG_W'(0))};
        return {ctx_op, idx, f};
    endfunction

    // Output slots driven from the two lowest remaining elements.
    always_comb begin
        out0_valid = (state == ST_RUN) & e0_ok;
        out1_valid = (state == ST_RUN) & e1_ok;
        out0_uop   = build_uop(e0);
        out1_uop   = build_uop(e1);
        done       = (state == ST_FIN);
    end
endmodule

// File: rtl/vis_seq_chk.sv
// Protocol checker for vis_seq, attached by bind. It observes top ports only.
module vis_seq_chk #(
    parameter int UOP_W  = 41,
    parameter int OP_W   = 8,
    parameter int MAX_VL = 64,
    localparam int IW    = $clog2(MAX_VL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             out_ready,
    input logic             out0_valid,
    input logic [UOP_W-1:0] out0_uop,
    input logic             out1_valid,
    input logic [UOP_W-1:0] out1_uop,
    input logic             done
);
    localparam int IDX_LO = UOP_W - OP_W - IW;

    assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out1_valid |-> out0_valid);

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_valid && out1_valid) |->
            (out1_uop[IDX_LO +: IW] > out0_uop[IDX_LO +: IW]));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_valid && !out_ready) |=>
            (out0_valid && $stable(out0_uop) && $stable(out1_valid) && $stable(out1_uop)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ins_ready));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ready |-> (!out0_valid && !done));

    assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |=> !ins_ready);
endmodule

bind vis_seq vis_seq_chk #(.UOP_W(UOP_W), .OP_W(OP_W), .MAX_VL(MAX_VL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .out_ready  (out_ready),
    .out0_valid (out0_valid),
    .out0_uop   (out0_uop),
    .out1_valid (out1_valid),
    .out1_uop   (out1_uop),
    .done       (done)
);

// File: tb/vis_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected micro-ops from its own tag
// model and queues them; the monitor pops and compares on every transfer.
module vis_seq_test;
    localparam int NT = 4, MVL = 64, OPW = 8;
    localparam int IW = 6, VLW = 7, UOPW = 41;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_valid = 0, cfg_vec = 0, vl_we = 0, ins_valid = 0, out_ready = 0;
    logic [1:0] cfg_slot = 0, cfg_ew = 0;
    logic [4:0] cfg_areg = 0, ins_rd = 0, ins_rs1 = 0, ins_rs2 = 0;
    logic [6:0] cfg_preg = 0;
    logic [VLW-1:0] vl_val = 0;
    logic [OPW-1:0] ins_op = 0;
    logic [MVL-1:0] ins_pred = 0;
    logic ins_ready, out0_valid, out1_valid, done;
    logic [UOPW-1:0] out0_uop, out1_uop;

    always #2 clk = ~clk;

    vis_seq uut (.*);

    int checks = 0, errors = 0, xfers = 0, bp_mode = 0;
    logic [UOPW-1:0] exp_q[$];
    logic       m_v[NT], m_vec[NT];
    logic [4:0] m_a[NT];
    logic [6:0] m_p[NT];
    logic [1:0] m_e[NT];
    int m_vl = 0;

    // Queue backpressure: 0 = always ready, 1 = random, 2 = stalled.
    always @(posedge clk) begin
        #1;
        out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 2) ? 1'b0 : ($urandom % 10 < 6);
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare every transferred slot.
    always @(negedge clk) begin
        if (rst_n && out0_valid && out_ready) begin
            xfers++;
            if (exp_q.size() == 0) chk(0, "R4 unexpected slot0 uop", 64'(out0_uop), 0);
            else begin
                logic [UOPW-1:0] e;
                e = exp_q.pop_front();
                chk(out0_uop === e, "R3/R9 slot0 uop", 64'(out0_uop), 64'(e));
            end
            if (out1_valid) begin
                if (exp_q.size() == 0) chk(0, "R4 unexpected slot1 uop", 64'(out1_uop), 0);
                else begin
                    logic [UOPW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out1_uop === e, "R4 slot1 uop", 64'(out1_uop), 64'(e));
                end
            end
        end
    end

    function automatic int find(input logic [4:0] a);
        for (int t = 0; t < NT; t++) if (m_v[t] && m_a[t] == a) return t;
        return -1;
    endfunction

    task automatic cfg(input int s, input bit v, input logic [4:0] a, input logic [6:0] p,
                       input logic [1:0] e, input bit vc);
        @(negedge clk);
        cfg_we = 1; cfg_slot = 2'(s); cfg_valid = v; cfg_areg = a; cfg_preg = p; cfg_ew = e; cfg_vec = vc;
        m_v[s] = v; m_a[s] = a; m_p[s] = p; m_e[s] = e; m_vec[s] = vc;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_vl(input int n);
        @(negedge clk);
        vl_we = 1; vl_val = VLW'(n); m_vl = n;
        @(negedge clk);
        vl_we = 0;
    endtask

    // Reference model: push the expected micro-op words; return their count.
    task automatic expect_uops(input logic [7:0] op, input logic [4:0] rd, input logic [4:0] r1,
                               input logic [4:0] r2, input logic [MVL-1:0] pred, output int n);
        logic [4:0] ar[3];
        logic [6:0] b[3];
        logic [1:0] w[3];
        bit vc[3], anyv;
        ar[0] = rd; ar[1] = r1; ar[2] = r2;
        anyv = 0; n = 0;
        for (int g = 0; g < 3; g++) begin
            int t;
            t = find(ar[g]);
            b[g] = (t >= 0) ? m_p[t] : {2'b00, ar[g]};
            w[g] = (t >= 0) ? m_e[t] : 2'b00;
            vc[g] = (t >= 0) && m_vec[t];
            anyv |= vc[g];
        end
        for (int i = 0; i < MVL; i++) begin
            if (anyv ? (pred[i] && i < m_vl) : (i == 0)) begin
                logic [6:0] r[3];
                for (int g = 0; g < 3; g++) r[g] = b[g] + (vc[g] ? 7'(i) : 7'd0);
                exp_q.push_back({op, 6'(i), w[0], r[0], w[1], r[1], w[2], r[2]});
                n++;
            end
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [4:0] rd, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [MVL-1:0] pred, output int n);
        do @(negedge clk); while (!ins_ready);
        expect_uops(op, rd, r1, r2, pred, n);
        ins_valid = 1; ins_op = op; ins_rd = rd; ins_rs1 = r1; ins_rs2 = r2; ins_pred = pred;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic finish_ins(input string req);
        int guard = 0;
        while (!done && guard < 500) begin @(negedge clk); guard++; end
        chk(done === 1'b1, "R8 done pulse seen", 64'(done), 1);
        chk(exp_q.size() == 0, {req, " all expected uops issued"}, exp_q.size(), 0);
        @(negedge clk);
        chk(ins_ready === 1'b1 && done === 1'b0, "R8 ready after done", {ins_ready, done}, 2'b10);
        exp_q.delete();
    endtask

    task automatic run(input logic [7:0] op, input logic [4:0] rd, input logic [4:0] r1,
                       input logic [4:0] r2, input logic [MVL-1:0] pred, input string req);
        int n;
        send(op, rd, r1, r2, pred, n);
        finish_ins(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, x0;
        logic [UOPW-1:0] held;
        for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_a[t] = 0; m_p[t] = 0; m_e[t] = 0; m_vec[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ins_ready === 1 && out0_valid === 0 && out1_valid === 0 && done === 0,
            "R1 reset state", {ins_ready, out0_valid, out1_valid, done}, 4'b1000);

        // R5/R2: nothing tagged -> one plain uop, predicate ignored.
        run(8'h11, 5'd3, 5'd4, 5'd5, '0, "R5 untagged scalar");

        // R3/R4: rd vector, VL 6, full mask, two per transfer.
        cfg(0, 1, 5'd3, 7'd100, 2'b01, 1);
        set_vl(6);
        x0 = xfers;
        run(8'h22, 5'd3, 5'd4, 5'd5, '1, "R3 vector expand");
        chk(xfers - x0 == 3, "R4 six elements in three transfers", xfers - x0, 3);

        // R4: sparse mask at VL 64, skipped runs cost nothing.
        set_vl(64);
        x0 = xfers;
        run(8'h23, 5'd3, 5'd4, 5'd5, 64'h0000_0100_0000_0021, "R4 sparse mask");
        chk(xfers - x0 == 2, "R4 three elements in two transfers", xfers - x0, 2);

        // R3: physical numbering wraps modulo 128.
        cfg(0, 1, 5'd3, 7'd126, 2'b11, 1);
        set_vl(4);
        run(8'h24, 5'd3, 5'd3, 5'd6, '1, "R3 wraparound");

        // R6: two architectural registers on one physical register, different widths.
        cfg(0, 1, 5'd3, 7'd100, 2'b01, 1);
        cfg(1, 1, 5'd4, 7'd100, 2'b10, 0);
        run(8'h25, 5'd3, 5'd4, 5'd9, 64'hF, "R6 shared physical");

        // R2: duplicate entries, lowest slot wins.
        cfg(2, 1, 5'd3, 7'd20, 2'b11, 0);
        run(8'h26, 5'd3, 5'd1, 5'd2, 64'h5, "R2 slot priority");

        // R5: only a non-vector tag -> single redirected uop.
        cfg(0, 0, 5'd3, 7'd0, 2'b00, 0);
        cfg(2, 0, 5'd3, 7'd0, 2'b00, 0);
        run(8'h27, 5'd4, 5'd4, 5'd7, '0, "R5 redirected scalar");

        // R11: vector tag with VL 0, then a mask empty within VL.
        cfg(0, 1, 5'd8, 7'd40, 2'b01, 1);
        set_vl(0);
        x0 = xfers;
        run(8'h28, 5'd8, 5'd1, 5'd2, '1, "R11 zero length");
        chk(xfers == x0, "R11 nothing issued at VL 0", xfers - x0, 0);
        set_vl(4);
        run(8'h29, 5'd8, 5'd1, 5'd2, 64'hF0, "R11 empty mask in range");

        // R7 and R10: stall, read slot 0, rewrite tags mid-flight, confirm no change.
        bp_mode = 2;
        send(8'h2A, 5'd8, 5'd8, 5'd2, 64'hA, n);
        @(negedge clk);
        held = out0_uop;
        cfg(0, 1, 5'd8, 7'd90, 2'b11, 0);
        set_vl(1);
        repeat (3) @(negedge clk);
        chk(out0_valid === 1 && out0_uop === held, "R7 stalled slot holds", 64'(out0_uop), 64'(held));
        chk(ins_ready === 0, "R8 busy while issuing", ins_ready, 0);
        bp_mode = 0;
        finish_ins("R10 late config ignored");

        // Random tags, masks, lengths and backpressure.
        bp_mode = 1;
        for (int k = 0; k < 40; k++) begin
            for (int t = 0; t < NT; t++)
                cfg(t, $urandom % 4 != 0, 5'($urandom % 8), 7'($urandom), 2'($urandom), $urandom % 2 == 0);
            set_vl($urandom % 71);
            run(8'($urandom), 5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
                {$urandom, $urandom}, "R3/R4 random");
        end
        bp_mode = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule